// File: doc/BRIEF.md
# Mailbox Exchange Requester

This block drives a single request/response exchange through a memory-mapped data-object mailbox. It has only a 32-bit register-access master port to reach the mailbox. A local client hands it a command made of a protocol vendor ID, an object type, a payload byte count and the size of the client's response buffer. The block streams the request object into the mailbox write register and starts the mailbox. It then polls status until a response is ready, drains the response through the read register and ends with a one-cycle completion carrying a result code and a length.

The block also recovers from mailbox trouble without software help. If the mailbox is busy at send time, it retries at a fixed interval for a bounded number of attempts. A status error or a response timeout makes it abort the mailbox. An abort that never completes leaves the block permanently dead, and from then on every command is refused at once. The client can also request an abort on its own, for example to put the mailbox in a known state after power-up. Only that kind of abort is acknowledged with a pulse.

Top module: `mbx_req_ctrl`

## Requirements
- R1: `cmd_ready_o` is 1 only while the controller is idle and no abort is being taken in the same cycle, so at most one exchange is ever in flight. After reset it is 1 and `dead_o` is 0.
- R2: A command whose byte count is not a multiple of four completes one cycle after acceptance with code 4 (invalid) and length 0, and makes no register access. This check takes precedence over the dead check.
- R3: An accepted command first reads status at 0x0C. It then writes to 0x10 a first header `{8'h00, type[7:0], vid[15:0]}`, a second header whose bits 17:0 hold the total dword count (payload + 2), and then the payload dwords in index order. Finally it writes 0x8000_0000 (start, bit 31) to control at 0x08.
- R4: If status bit 0 (busy) is set at the pre-send read, the read is repeated after `RETRY_CYC` cycles. After `RETRY_MAX` consecutive busy reads, the command completes with code 1 (busy). No object is written and no abort is issued.
- R5: If status bit 2 (error) is set at the pre-send read or while waiting for the response, the command completes with code 2 (I/O error) and an error abort follows.
- R6: After the start write, status is re-read every `POLL_CYC` cycles while bit 31 (ready) is clear. If a poll finds ready clear after `TMO_CYC` cycles have passed, the command completes with code 3 (timeout) and an error abort follows.
- R7: Once the response is ready, each response dword is read from 0x14 and then popped by a write to 0x14. The second header's bits 17:0 give the total dword count. Payload dword k is presented on `rsp_*` only when k < `cmd_rsp_max_i`. Dwords beyond that are still read and popped.
- R8: A successful exchange completes with code 0. The length is the full received payload in bytes, including any dwords that were discarded.
- R9: An abort writes 0x0000_0001 (abort, bit 0) to 0x08. It then polls status every `POLL_CYC` cycles and returns to idle only when status bits 0 and 2 both read 0. No command is accepted while an abort runs.
- R10: `abort_done_o` pulses only at the end of an abort that was requested through `abort_i`, never at the end of an error abort.
- R11: If an abort has not finished when a poll occurs `TMO_CYC` cycles after its control write, `dead_o` is set and stays set until reset. `abort_done_o` still pulses if the abort was deliberate. Every later valid command completes with code 2 and makes no register access.
- R12: `abort_i` is taken only in idle, and it wins over a simultaneous command. While `dead_o` is 1, `abort_i` is ignored.
- R13: On the register port, `reg_req_o`, `reg_we_o`, `reg_addr_o` and `reg_wdata_o` hold steady from the start of an access until the cycle `reg_ack_i` is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command request |
| cmd_ready_o | output | 1 | Command accepted when high with valid |
| cmd_vid_i | input | 16 | Protocol vendor ID |
| cmd_type_i | input | 8 | Protocol object type |
| cmd_bytes_i | input | 20 | Request payload size in bytes |
| cmd_rsp_max_i | input | BUF_W | Client response buffer size in dwords |
| abort_i | input | 1 | Deliberate abort request |
| abort_done_o | output | 1 | Pulse: deliberate abort finished |
| pl_idx_o | output | 18 | Index of the request payload dword wanted |
| pl_data_i | input | 32 | Request payload dword at `pl_idx_o` |
| rsp_valid_o | output | 1 | Response payload dword valid |
| rsp_idx_o | output | 18 | Index of the response dword |
| rsp_data_o | output | 32 | Response payload dword |
| done_o | output | 1 | Pulse: command finished |
| done_code_o | output | 3 | Result: 0 ok, 1 busy, 2 I/O, 3 timeout, 4 invalid |
| done_len_o | output | 20 | Received payload bytes |
| dead_o | output | 1 | Sticky: mailbox unrecoverable |
| reg_req_o | output | 1 | Register access request |
| reg_we_o | output | 1 | Access is a write |
| reg_addr_o | output | 8 | Register byte offset |
| reg_wdata_o | output | 32 | Write data |
| reg_ack_i | input | 1 | Access completes this cycle |
| reg_rdata_i | input | 32 | Read data, valid with ack |

## Verification
The dead state is the hardest condition to reach. It needs an abort whose status poll keeps reporting busy for longer than the timeout, and nothing on the command side can cause that. The bench's behavioural mailbox therefore reloads a configurable busy count on every abort write. Setting that count beyond any reachable poll total makes the deliberate abort run out its timeout. That same model also drives the retry-exhaustion, error-during-wait and response-timeout paths from per-test knobs, while random exchanges vary payload sizes, buffer truncation, ready latency and acknowledge delay.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int unsigned OBJ_LEN_W = 18;

  localparam logic [7:0] A_CTRL = 8'h08;
  localparam logic [7:0] A_STAT = 8'h0C;
  localparam logic [7:0] A_WDAT = 8'h10;
  localparam logic [7:0] A_RDAT = 8'h14;

  localparam logic [2:0] RC_OK    = 3'd0;
  localparam logic [2:0] RC_BUSY  = 3'd1;
  localparam logic [2:0] RC_IO    = 3'd2;
  localparam logic [2:0] RC_TMO   = 3'd3;
  localparam logic [2:0] RC_INVAL = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_RETRY, S_WR, S_GO, S_POLL, S_PWAIT,
    S_RD, S_POP, S_ABT_WR, S_ABT_POLL, S_ABT_WAIT
  } mbx_state_e;
endpackage

// File: rtl/mbx_timer.sv
module mbx_timer #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);
endmodule

// File: rtl/mbx_reg_port.sv
module mbx_reg_port (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        start_i,
  input  logic        we_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic        done_o,
  output logic [31:0] rdata_o,
  output logic        reg_req_o,
  output logic        reg_we_o,
  output logic [7:0]  reg_addr_o,
  output logic [31:0] reg_wdata_o,
  input  logic        reg_ack_i,
  input  logic [31:0] reg_rdata_i
);
  logic        req_q, we_q;
  logic [7:0]  addr_q;
  logic [31:0] wdata_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0; we_q <= 1'b0; addr_q <= '0; wdata_q <= '0;
    end else if (!req_q && start_i) begin
      req_q <= 1'b1; we_q <= we_i; addr_q <= addr_i; wdata_q <= wdata_i;
    end else if (req_q && reg_ack_i) begin
      req_q <= 1'b0;
    end
  end

  assign done_o      = req_q & reg_ack_i;
  assign rdata_o     = reg_rdata_i;
  assign reg_req_o   = req_q;
  assign reg_we_o    = we_q;
  assign reg_addr_o  = addr_q;
  assign reg_wdata_o = wdata_q;

  assert_req_hold_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_req_o && !reg_ack_i |=> reg_req_o && $stable(reg_addr_o) && $stable(reg_we_o)
                                && $stable(reg_wdata_o));
endmodule

// File: rtl/mbx_req_ctrl.sv
module mbx_req_ctrl
  import mbx_pkg::*;
#(
  parameter int unsigned TMO_CYC   = 250_000_000,
  parameter int unsigned POLL_CYC  = 2_500,
  parameter int unsigned RETRY_CYC = 25_000_000,
  parameter int unsigned RETRY_MAX = 10,
  parameter int unsigned BUF_W     = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cmd_valid_i,
  output logic                 cmd_ready_o,
  input  logic [15:0]          cmd_vid_i,
  input  logic [7:0]           cmd_type_i,
  input  logic [OBJ_LEN_W+1:0] cmd_bytes_i,
  input  logic [BUF_W-1:0]     cmd_rsp_max_i,
  input  logic                 abort_i,
  output logic                 abort_done_o,
  output logic [OBJ_LEN_W-1:0] pl_idx_o,
  input  logic [31:0]          pl_data_i,
  output logic                 rsp_valid_o,
  output logic [OBJ_LEN_W-1:0] rsp_idx_o,
  output logic [31:0]          rsp_data_o,
  output logic                 done_o,
  output logic [2:0]           done_code_o,
  output logic [OBJ_LEN_W+1:0] done_len_o,
  output logic                 dead_o,
  output logic                 reg_req_o,
  output logic                 reg_we_o,
  output logic [7:0]           reg_addr_o,
  output logic [31:0]          reg_wdata_o,
  input  logic                 reg_ack_i,
  input  logic [31:0]          reg_rdata_i
);
  localparam int unsigned TMAX0 = (TMO_CYC > POLL_CYC) ? TMO_CYC : POLL_CYC;
  localparam int unsigned TMAX  = (TMAX0 > RETRY_CYC) ? TMAX0 : RETRY_CYC;
  localparam int unsigned CNT_W = $clog2(TMAX + 1);
  localparam int unsigned RC_W  = $clog2(RETRY_MAX + 1);
  localparam logic [OBJ_LEN_W-1:0] TWO = OBJ_LEN_W'(2);

  mbx_state_e st_q;
  logic [15:0]          vid_q;
  logic [7:0]           type_q;
  logic [OBJ_LEN_W-1:0] pl_dw_q, wr_idx_q, rd_idx_q, rd_tot_q;
  logic [BUF_W-1:0]     rsp_max_q;
  logic [RC_W-1:0]      retry_q;
  logic                 abt_err_q, dead_q;
  logic                 done_q, abort_done_q, rsp_valid_q;
  logic [2:0]           code_q;
  logic [OBJ_LEN_W+1:0] len_q;
  logic [OBJ_LEN_W-1:0] rsp_idx_q;
  logic [31:0]          rsp_data_q;

  logic        acc_start, acc_we, acc_done;
  logic [7:0]  acc_addr;
  logic [31:0] acc_wdata, acc_rdata;
  logic        gap_ld, gap_exp, tmo_ld, tmo_exp;
  logic        take_abort;
  logic        s_busy, s_err, s_rdy;

  assign s_busy = acc_rdata[0];
  assign s_err  = acc_rdata[2];
  assign s_rdy  = acc_rdata[31];

  assign take_abort  = (st_q == S_IDLE) && abort_i && !dead_q;
  assign cmd_ready_o = (st_q == S_IDLE) && !take_abort;
  assign pl_idx_o    = wr_idx_q - TWO;

  always_comb begin
    acc_start = 1'b1;
    acc_we    = 1'b0;
    acc_addr  = A_STAT;
    acc_wdata = '0;
    unique case (st_q)
      S_CHK, S_POLL, S_ABT_POLL: ;
      S_WR: begin
        acc_we   = 1'b1;
        acc_addr = A_WDAT;
        if (wr_idx_q == '0)      acc_wdata = {8'h00, type_q, vid_q};
        else if (wr_idx_q == 1)  acc_wdata = 32'(pl_dw_q + TWO);
        else                     acc_wdata = pl_data_i;
      end
      S_GO:     begin acc_we = 1'b1; acc_addr = A_CTRL; acc_wdata = 32'h8000_0000; end
      S_RD:     acc_addr = A_RDAT;
      S_POP:    begin acc_we = 1'b1; acc_addr = A_RDAT; end
      S_ABT_WR: begin acc_we = 1'b1; acc_addr = A_CTRL; acc_wdata = 32'h0000_0001; end
      default:  acc_start = 1'b0;
    endcase
  end

  // reload the gap on every status read; unused unless a wait state follows
  assign gap_ld = acc_done && (st_q == S_CHK || st_q == S_POLL || st_q == S_ABT_POLL);
  assign tmo_ld = acc_done && (st_q == S_GO || st_q == S_ABT_WR);

  mbx_reg_port u_port (
    .clk_i, .rst_ni,
    .start_i(acc_start), .we_i(acc_we), .addr_i(acc_addr), .wdata_i(acc_wdata),
    .done_o(acc_done), .rdata_o(acc_rdata),
    .reg_req_o, .reg_we_o, .reg_addr_o, .reg_wdata_o, .reg_ack_i, .reg_rdata_i
  );

  mbx_timer #(.CNT_W(CNT_W)) u_gap (
    .clk_i, .rst_ni, .load_i(gap_ld),
    .val_i((st_q == S_CHK) ? CNT_W'(RETRY_CYC) : CNT_W'(POLL_CYC)),
    .expired_o(gap_exp)
  );

  mbx_timer #(.CNT_W(CNT_W)) u_tmo (
    .clk_i, .rst_ni, .load_i(tmo_ld), .val_i(CNT_W'(TMO_CYC)), .expired_o(tmo_exp)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; vid_q <= '0; type_q <= '0; pl_dw_q <= '0; rsp_max_q <= '0;
      wr_idx_q <= '0; rd_idx_q <= '0; rd_tot_q <= '0; retry_q <= '0;
      abt_err_q <= 1'b0; dead_q <= 1'b0; done_q <= 1'b0; abort_done_q <= 1'b0;
      rsp_valid_q <= 1'b0; code_q <= RC_OK; len_q <= '0; rsp_idx_q <= '0; rsp_data_q <= '0;
    end else begin
      done_q       <= 1'b0;
      abort_done_q <= 1'b0;
      rsp_valid_q  <= 1'b0;
      unique case (st_q)
        S_IDLE: begin
          if (take_abort) begin
            abt_err_q <= 1'b0;
            st_q      <= S_ABT_WR;
          end else if (cmd_valid_i) begin
            vid_q     <= cmd_vid_i;
            type_q    <= cmd_type_i;
            pl_dw_q   <= cmd_bytes_i[OBJ_LEN_W+1:2];
            rsp_max_q <= cmd_rsp_max_i;
            len_q     <= '0;
            if (cmd_bytes_i[1:0] != 2'b00) begin
              done_q <= 1'b1; code_q <= RC_INVAL;
            end else if (dead_q) begin
              done_q <= 1'b1; code_q <= RC_IO;
            end else begin
              retry_q <= '0;
              st_q    <= S_CHK;
            end
          end
        end
        S_CHK: if (acc_done) begin
          if (s_err) begin
            done_q <= 1'b1; code_q <= RC_IO; abt_err_q <= 1'b1; st_q <= S_ABT_WR;
          end else if (s_busy) begin
            if (retry_q == RC_W'(RETRY_MAX - 1)) begin
              done_q <= 1'b1; code_q <= RC_BUSY; retry_q <= '0; st_q <= S_IDLE;
            end else begin
              retry_q <= retry_q + 1'b1;
              st_q    <= S_RETRY;
            end
          end else begin
            wr_idx_q <= '0;
            st_q     <= S_WR;
          end
        end
        S_RETRY: if (gap_exp) st_q <= S_CHK;
        S_WR: if (acc_done) begin
          if (wr_idx_q == pl_dw_q + 1'b1) st_q <= S_GO;
          else                            wr_idx_q <= wr_idx_q + 1'b1;
        end
        S_GO: if (acc_done) st_q <= S_POLL;
        S_POLL: if (acc_done) begin
          if (s_err) begin
            done_q <= 1'b1; code_q <= RC_IO; abt_err_q <= 1'b1; st_q <= S_ABT_WR;
          end else if (s_rdy) begin
            rd_idx_q <= '0; rd_tot_q <= TWO; st_q <= S_RD;
          end else if (tmo_exp) begin
            done_q <= 1'b1; code_q <= RC_TMO; abt_err_q <= 1'b1; st_q <= S_ABT_WR;
          end else begin
            st_q <= S_PWAIT;
          end
        end
        S_PWAIT: if (gap_exp) st_q <= S_POLL;
        S_RD: if (acc_done) begin
          if (rd_idx_q == 1)
            rd_tot_q <= (acc_rdata[OBJ_LEN_W-1:0] < TWO) ? TWO : acc_rdata[OBJ_LEN_W-1:0];
          if (rd_idx_q >= TWO && (rd_idx_q - TWO) < OBJ_LEN_W'(rsp_max_q)) begin
            rsp_valid_q <= 1'b1;
            rsp_idx_q   <= rd_idx_q - TWO;
            rsp_data_q  <= acc_rdata;
          end
          st_q <= S_POP;
        end
        S_POP: if (acc_done) begin
          if (rd_idx_q + 1'b1 == rd_tot_q) begin
            done_q <= 1'b1; code_q <= RC_OK; len_q <= {rd_tot_q - TWO, 2'b00}; st_q <= S_IDLE;
          end else begin
            rd_idx_q <= rd_idx_q + 1'b1;
            st_q     <= S_RD;
          end
        end
        S_ABT_WR: if (acc_done) st_q <= S_ABT_POLL;
        S_ABT_POLL: if (acc_done) begin
          if (!s_err && !s_busy) begin
            abort_done_q <= !abt_err_q;
            st_q         <= S_IDLE;
          end else if (tmo_exp) begin
            dead_q       <= 1'b1;
            abort_done_q <= !abt_err_q;
            st_q         <= S_IDLE;
          end else begin
            st_q <= S_ABT_WAIT;
          end
        end
        S_ABT_WAIT: if (gap_exp) st_q <= S_ABT_POLL;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign abort_done_o = abort_done_q;
  assign rsp_valid_o  = rsp_valid_q;
  assign rsp_idx_o    = rsp_idx_q;
  assign rsp_data_o   = rsp_data_q;
  assign done_o       = done_q;
  assign done_code_o  = code_q;
  assign done_len_o   = len_q;
  assign dead_o       = dead_q;

  assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_q == S_IDLE |-> !reg_req_o);
  assert_accept_moves_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_ready_o |=> (st_q != S_IDLE) || done_o);
  assert_retry_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    retry_q < RC_W'(RETRY_MAX));
  assert_rsp_in_buf_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> rsp_idx_o < OBJ_LEN_W'(rsp_max_q));
  assert_abort_done_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_done_o |-> st_q == S_IDLE && !done_o);
  assert_dead_sticky_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dead_o |=> dead_o);
endmodule

// File: tb/tb_mbx_req_ctrl.sv
module tb_mbx_req_ctrl;
  localparam int RMAX = 4;
  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic cmd_valid = 0, cmd_ready, abort_req = 0, abort_done;
  logic [15:0] cmd_vid = 0;
  logic [7:0] cmd_type = 0;
  logic [19:0] cmd_bytes = 0;
  logic [7:0] cmd_rmax = 0;
  logic [17:0] pl_idx, rsp_idx;
  logic [31:0] pl_data, rsp_data;
  logic rsp_valid, done, dead;
  logic [2:0] done_code;
  logic [19:0] done_len;
  logic reg_req, reg_we, reg_ack = 0;
  logic [7:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata = 0;

  logic [31:0] pl_buf [0:31];
  logic [31:0] rsp_mem [0:31];
  logic [31:0] wr_log [0:31];
  logic [31:0] cap [0:31];
  assign pl_data = pl_buf[pl_idx[4:0]];

  mbx_req_ctrl #(.TMO_CYC(400), .POLL_CYC(6), .RETRY_CYC(10), .RETRY_MAX(RMAX), .BUF_W(8)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_vid_i(cmd_vid), .cmd_type_i(cmd_type), .cmd_bytes_i(cmd_bytes), .cmd_rsp_max_i(cmd_rmax),
    .abort_i(abort_req), .abort_done_o(abort_done), .pl_idx_o(pl_idx), .pl_data_i(pl_data),
    .rsp_valid_o(rsp_valid), .rsp_idx_o(rsp_idx), .rsp_data_o(rsp_data),
    .done_o(done), .done_code_o(done_code), .done_len_o(done_len), .dead_o(dead),
    .reg_req_o(reg_req), .reg_we_o(reg_we), .reg_addr_o(reg_addr), .reg_wdata_o(reg_wdata),
    .reg_ack_i(reg_ack), .reg_rdata_i(reg_rdata));

  int checks = 0, errors = 0;
  int busy_left = 0, abt_busy = 0, rdy_left = 0, rsp_ptr = 0;
  bit err_f = 0, err_on_go = 0, go_seen = 0, hold = 0;
  int st_n = 0, wr_n = 0, go_n = 0, abt_n = 0, acc_n = 0, unstable = 0;
  int done_n = 0, ad_n = 0, cap_n = 0;
  logic [2:0] last_code;
  logic [19:0] last_len;
  logic [7:0] h_addr; logic h_we; logic [31:0] h_wdata;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // behavioural mailbox, acts between clock edges
  always @(negedge clk) begin
    if (hold) begin
      if (!(reg_req && reg_addr == h_addr && reg_we == h_we && reg_wdata == h_wdata)) unstable++;
    end
    if (reg_ack) reg_ack = 0;
    else if (reg_req && ($urandom % 4) != 0) begin
      acc_n++;
      reg_ack = 1;
      reg_rdata = 0;
      if (reg_addr == 8'h0C && !reg_we) begin
        st_n++;
        reg_rdata[0] = (busy_left > 0);
        reg_rdata[2] = err_f;
        reg_rdata[31] = go_seen && rdy_left == 0;
        if (busy_left > 0) busy_left--;
        if (go_seen && rdy_left > 0) rdy_left--;
      end else if (reg_addr == 8'h10 && reg_we) begin
        wr_log[wr_n % 32] = reg_wdata; wr_n++;
      end else if (reg_addr == 8'h08 && reg_we) begin
        if (reg_wdata[31]) begin go_n++; go_seen = 1; if (err_on_go) err_f = 1; end
        if (reg_wdata[0]) begin abt_n++; go_seen = 0; err_f = 0; busy_left = abt_busy; end
      end else if (reg_addr == 8'h14) begin
        if (reg_we) rsp_ptr++;
        else reg_rdata = rsp_mem[rsp_ptr % 32];
      end
    end
    hold = reg_req && !reg_ack;
    h_addr = reg_addr; h_we = reg_we; h_wdata = reg_wdata;
  end

  always @(negedge clk) begin
    if (done) begin done_n++; last_code = done_code; last_len = done_len; end
    if (abort_done) ad_n++;
    if (rsp_valid) begin cap[rsp_idx[4:0]] = rsp_data; cap_n++; end
  end

  task automatic wait_ready();
    for (int i = 0; i < 5000 && !cmd_ready; i++) @(negedge clk);
  endtask

  task automatic do_cmd(input logic [15:0] v, input logic [7:0] t, input int bytes, input int rmax);
    int d0;
    wait_ready();
    d0 = done_n;
    cmd_vid = v; cmd_type = t; cmd_bytes = 20'(bytes); cmd_rmax = 8'(rmax);
    cmd_valid = 1;
    @(negedge clk);
    cmd_valid = 0;
    for (int i = 0; i < 5000 && done_n == d0; i++) @(negedge clk);
    wait_ready();
  endtask

  task automatic pulse_abort();
    abort_req = 1;
    @(negedge clk);
    abort_req = 0;
  endtask

  task automatic setup_rsp(input int n);
    rsp_mem[0] = $urandom;
    rsp_mem[1] = 32'(n + 2);
    for (int i = 0; i < n; i++) rsp_mem[i + 2] = $urandom;
    rsp_ptr = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int a0, w0, g0, b0, s0, d0, ad0, bad, n_pl, n_rsp, rm, exp_cap;
    logic [15:0] v; logic [7:0] t;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(cmd_ready && !dead && !reg_req, "R1 reset", {cmd_ready, dead, reg_req}, 3'b100);

    // R3 R7 R8 R4 random exchanges
    for (int it = 0; it < 30; it++) begin
      n_pl = $urandom % 6; n_rsp = $urandom % 6; rm = $urandom % 7;
      busy_left = $urandom % RMAX; rdy_left = $urandom % 4;
      v = 16'($urandom); t = 8'($urandom);
      for (int i = 0; i < n_pl; i++) pl_buf[i] = $urandom;
      setup_rsp(n_rsp);
      go_seen = 0; err_f = 0; err_on_go = 0;
      w0 = wr_n; g0 = go_n; cap_n = 0;
      do_cmd(v, t, n_pl * 4, rm);
      chk(last_code == 3'd0, "R8 code", last_code, 0);
      chk(last_len == 20'(n_rsp * 4), "R8 len", last_len, n_rsp * 4);
      bad = 0;
      if (wr_n - w0 != n_pl + 2 || go_n - g0 != 1) bad++;
      else begin
        if (wr_log[w0 % 32] != {8'h00, t, v}) bad++;
        if (wr_log[(w0 + 1) % 32] != 32'(n_pl + 2)) bad++;
        for (int i = 0; i < n_pl; i++) if (wr_log[(w0 + 2 + i) % 32] != pl_buf[i]) bad++;
      end
      chk(bad == 0, "R3 object write", wr_n - w0, n_pl + 2);
      exp_cap = (rm < n_rsp) ? rm : n_rsp;
      bad = 0;
      for (int i = 0; i < exp_cap; i++) if (cap[i] != rsp_mem[i + 2]) bad++;
      chk(cap_n == exp_cap && bad == 0, "R7 response", cap_n, exp_cap);
      chk(rsp_ptr == n_rsp + 2, "R7 pops", rsp_ptr, n_rsp + 2);
    end
    busy_left = 0; rdy_left = 0; go_seen = 0;

    // R2 invalid length
    a0 = acc_n;
    do_cmd(16'h1, 8'h2, 6, 4);
    chk(last_code == 3'd4 && acc_n == a0, "R2 invalid", last_code, 4);

    // R4 busy exhaustion
    busy_left = 1000; s0 = st_n; w0 = wr_n; b0 = abt_n;
    do_cmd(16'h1, 8'h2, 8, 4);
    chk(last_code == 3'd1, "R4 busy code", last_code, 1);
    chk(st_n - s0 == RMAX && wr_n == w0 && abt_n == b0, "R4 busy reads", st_n - s0, RMAX);
    busy_left = 0;

    // R5 R10 error before send
    err_f = 1; w0 = wr_n; b0 = abt_n; ad0 = ad_n;
    do_cmd(16'h1, 8'h2, 8, 4);
    chk(last_code == 3'd2 && wr_n == w0, "R5 pre-send error", last_code, 2);
    chk(abt_n - b0 == 1 && ad_n == ad0, "R10 error abort silent", ad_n - ad0, 0);

    // R5 error while waiting
    err_on_go = 1; g0 = go_n; b0 = abt_n; setup_rsp(1);
    do_cmd(16'h1, 8'h2, 4, 4);
    chk(last_code == 3'd2 && go_n - g0 == 1 && abt_n - b0 == 1, "R5 wait error", last_code, 2);
    err_on_go = 0;

    // R6 timeout
    rdy_left = 100000; b0 = abt_n; s0 = st_n;
    do_cmd(16'h1, 8'h2, 4, 4);
    chk(last_code == 3'd3 && abt_n - b0 == 1, "R6 timeout", last_code, 3);
    chk(st_n - s0 > 10, "R6 polling", st_n - s0, 11);
    rdy_left = 0;

    // R9 R10 R12 deliberate abort wins over simultaneous command
    abt_busy = 3; b0 = abt_n; ad0 = ad_n; d0 = done_n; w0 = wr_n; a0 = acc_n;
    wait_ready();
    cmd_valid = 1; abort_req = 1;
    @(negedge clk);
    cmd_valid = 0; abort_req = 0;
    chk(!cmd_ready, "R9 busy during abort", cmd_ready, 0);
    for (int i = 0; i < 3000 && ad_n == ad0; i++) @(negedge clk);
    chk(ad_n - ad0 == 1 && abt_n - b0 == 1 && !dead, "R10 abort done", ad_n - ad0, 1);
    chk(done_n == d0 && wr_n == w0, "R12 abort priority", done_n - d0, 0);
    chk(acc_n - a0 == 5, "R9 abort polls until clear", acc_n - a0, 5);

    // R11 abort never clears
    abt_busy = 1000000; ad0 = ad_n;
    wait_ready();
    pulse_abort();
    for (int i = 0; i < 3000 && ad_n == ad0; i++) @(negedge clk);
    @(negedge clk);
    chk(dead && ad_n - ad0 == 1, "R11 dead", dead, 1);
    a0 = acc_n;
    do_cmd(16'h1, 8'h2, 8, 4);
    chk(last_code == 3'd2 && acc_n == a0, "R11 reject after dead", last_code, 2);
    do_cmd(16'h1, 8'h2, 7, 4);
    chk(last_code == 3'd4, "R2 invalid precedes dead", last_code, 4);

    // R12 abort ignored when dead
    ad0 = ad_n; a0 = acc_n;
    pulse_abort();
    repeat (20) @(negedge clk);
    chk(ad_n == ad0 && acc_n == a0 && cmd_ready && dead, "R12 abort ignored dead", acc_n - a0, 0);

    chk(unstable == 0, "R13 port stability", unstable, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule